// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address by reading a radix page table that lives in memory. The walk starts at a root table whose page number is supplied on an input, and visits four levels. Each level uses one 9-bit slice of the address to pick an 8-byte entry, and the walk moves through those slices from the most significant downward. Every entry is read over a single memory port that can read or write. The walker decodes each entry and checks it against the access type and the privilege of the requester. It sets the accessed and dirty flags where the access calls for them. When the walk ends it returns either the final page number and entry or a fault code.

A requester offers one walk at a time through a valid/ready handshake. The walk runs to completion, and the result appears as a single-cycle response pulse. The memory port keeps its request asserted until the memory acknowledges it. An entry is written back only when one of its flags actually changes. The walk does not read the next level until that write has been acknowledged.

Top module: `pt_walker`

## Requirements
- R1: The entry address for level L (L = 0..3) is {table page number, va[47-9L : 39-9L], 3'b000}, so level 0 uses va[47:39] and level 3 uses va[20:12].
- R2: Level 0 uses root_ppn_i as the table page number. Every later level uses bits 51:12 of the entry read one level up.
- R3: If an entry has bit 0 (present) clear, the walk stops at once with fault code 1 (not present), and that entry is not written.
- R4: At any level the walk stops with fault code 2 (protection), and leaves the entry unwritten, in three cases: a write access (code 1) meets bit 1 = 0 (read-only); a user request meets bit 2 = 0 (supervisor only); an instruction fetch (code 2) meets bit 63 = 1 (execute disabled).
- R5: Every entry that passes its checks has bit 5 (accessed) set. It is written back only when that bit, or the dirty bit, was clear before.
- R6: Bit 6 (dirty) is set only in the level-3 entry, and only for write accesses.
- R7: Memory accesses follow the walk order: each read is followed by that entry's writeback, if one is needed, before the next level is read. A request stays asserted with a stable address until it is acknowledged.
- R8: A successful walk returns fault code 0. It also returns the page number from bits 51:12 of the final entry, the physical address {page number, va[11:0]}, and the final entry as written back. A faulting walk returns page number 0, address 0, and the faulting entry as it was read.
- R9: The walker is ready only when idle. rsp_valid_o is high for exactly one cycle. With D cycles from request to acknowledge, the response comes R*(D+1) + W*D + 1 cycles after acceptance, where R is the number of reads and W the number of writes.
- R10: Access code 3 behaves exactly like a read (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Walk request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 48 | Virtual address |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 read |
| req_user_i | input | 1 | 1 = user-mode request |
| root_ppn_i | input | 40 | Page number of the level-0 table |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 52 | Entry physical address |
| mem_wdata_o | output | 64 | Updated entry for a write |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 64 | Read data, valid with acknowledge |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_ppn_o | output | 40 | Translated page number |
| rsp_paddr_o | output | 52 | Translated physical address |
| rsp_pte_o | output | 64 | Final or faulting entry |

## Verification
The bench drives the memory acknowledge itself, after a delay it sets, so it knows exactly when each access completes. From the translation rules alone it builds the expected sequence of reads and writes and the expected result. It then derives the response cycle as R*(D+1) + W*D + 1 after acceptance. On every falling edge it compares the ready and response-valid outputs with the state it tracks. Each access is checked on the cycle its acknowledge is given, and the response fields are checked in the one cycle where the pulse is due. The delay is varied so that the latency formula is exercised with more than one value.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int unsigned VA_W   = 48;
  localparam int unsigned PA_W   = 52;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned IDX_W  = 9;
  localparam int unsigned LEVELS = 4;
  localparam int unsigned PTE_W  = 64;
  localparam int unsigned PPN_W  = PA_W - OFF_W;
  localparam int unsigned LVL_W  = $clog2(LEVELS);
  localparam int unsigned ENT_SH = OFF_W - IDX_W;

  localparam int unsigned PTE_P  = 0;
  localparam int unsigned PTE_RW = 1;
  localparam int unsigned PTE_US = 2;
  localparam int unsigned PTE_A  = 5;
  localparam int unsigned PTE_D  = 6;
  localparam int unsigned PTE_XD = 63;

  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2, ACC_RD2 = 2'd3} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_ABSENT = 2'd1, FLT_PERM = 2'd2} fault_e;
endpackage

// File: rtl/pt_idx_sel.sv
module pt_idx_sel
  import pt_walk_pkg::*;
(
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [PPN_W-1:0] base_i,
  output logic [PA_W-1:0]  ent_addr_o
);
  logic [IDX_W-1:0] idx_tab [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_tab[g] = vaddr_i[VA_W-1-g*IDX_W -: IDX_W];
  end

  assign ent_addr_o = {base_i, idx_tab[level_i], {ENT_SH{1'b0}}};
endmodule

// File: rtl/pt_pte_eval.sv
module pt_pte_eval
  import pt_walk_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  input  acc_e             acc_i,
  input  logic             user_i,
  input  logic             last_i,
  output logic             present_o,
  output logic             perm_ok_o,
  output logic [PTE_W-1:0] pte_upd_o,
  output logic             wb_o,
  output logic [PPN_W-1:0] next_ppn_o
);
  logic deny;

  assign present_o = pte_i[PTE_P];
  assign deny = ((acc_i == ACC_WR) && !pte_i[PTE_RW]) ||
                (user_i && !pte_i[PTE_US]) ||
                ((acc_i == ACC_EX) && pte_i[PTE_XD]);
  assign perm_ok_o = !deny;

  always_comb begin
    pte_upd_o        = pte_i;
    pte_upd_o[PTE_A] = 1'b1;
    if (last_i && (acc_i == ACC_WR)) pte_upd_o[PTE_D] = 1'b1;
  end

  assign wb_o       = (pte_upd_o != pte_i);
  assign next_ppn_o = pte_i[OFF_W +: PPN_W];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_acc_i,
  input  logic             req_user_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_fault_o,
  output logic [PPN_W-1:0] rsp_ppn_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [PTE_W-1:0] rsp_pte_o
);
  typedef enum logic [2:0] {S_IDLE, S_READ, S_EVAL, S_WRITE, S_DONE} state_e;

  state_e           state_q;
  logic [LVL_W-1:0] level_q;
  logic [VA_W-1:0]  vaddr_q;
  acc_e             acc_q;
  logic             user_q;
  logic [PPN_W-1:0] base_q, ppn_q;
  logic [PTE_W-1:0] pte_q;
  fault_e           fault_q;

  logic             last, present, perm_ok, need_wb;
  logic [PTE_W-1:0] pte_upd;
  logic [PPN_W-1:0] next_ppn;

  assign last = (level_q == LVL_W'(LEVELS-1));

  pt_idx_sel u_idx (
    .vaddr_i   (vaddr_q),
    .level_i   (level_q),
    .base_i    (base_q),
    .ent_addr_o(mem_addr_o)
  );

  pt_pte_eval u_eval (
    .pte_i     (pte_q),
    .acc_i     (acc_q),
    .user_i    (user_q),
    .last_i    (last),
    .present_o (present),
    .perm_ok_o (perm_ok),
    .pte_upd_o (pte_upd),
    .wb_o      (need_wb),
    .next_ppn_o(next_ppn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      level_q <= '0;
      vaddr_q <= '0;
      acc_q   <= ACC_RD;
      user_q  <= 1'b0;
      base_q  <= '0;
      ppn_q   <= '0;
      pte_q   <= '0;
      fault_q <= FLT_NONE;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          vaddr_q <= req_vaddr_i;
          acc_q   <= acc_e'(req_acc_i);
          user_q  <= req_user_i;
          base_q  <= root_ppn_i;
          level_q <= '0;
          state_q <= S_READ;
        end
        S_READ: if (mem_ack_i) begin
          pte_q   <= mem_rdata_i;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          if (!present) begin
            fault_q <= FLT_ABSENT;
            ppn_q   <= '0;
            state_q <= S_DONE;
          end else if (!perm_ok) begin
            fault_q <= FLT_PERM;
            ppn_q   <= '0;
            state_q <= S_DONE;
          end else begin
            pte_q <= pte_upd;
            if (need_wb) begin
              state_q <= S_WRITE;
            end else if (last) begin
              fault_q <= FLT_NONE;
              ppn_q   <= next_ppn;
              state_q <= S_DONE;
            end else begin
              level_q <= level_q + LVL_W'(1);
              base_q  <= next_ppn;
              state_q <= S_READ;
            end
          end
        end
        S_WRITE: if (mem_ack_i) begin
          if (last) begin
            fault_q <= FLT_NONE;
            ppn_q   <= next_ppn;
            state_q <= S_DONE;
          end else begin
            level_q <= level_q + LVL_W'(1);
            base_q  <= next_ppn;
            state_q <= S_READ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_READ) || (state_q == S_WRITE);
  assign mem_we_o    = (state_q == S_WRITE);
  assign mem_wdata_o = pte_q;
  assign rsp_valid_o = (state_q == S_DONE);
  assign rsp_fault_o = fault_q;
  assign rsp_ppn_o   = ppn_q;
  assign rsp_paddr_o = (fault_q == FLT_NONE) ? {ppn_q, vaddr_q[OFF_W-1:0]} : '0;
  assign rsp_pte_o   = pte_q;

  // R5: any writeback carries the accessed flag
  a_r5_wb_sets_accessed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[PTE_A]);

  // R7: request held with stable address until acknowledged
  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R8: successful result carries a present, accessed entry
  a_r8_ok_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_fault_o == 2'd0) |-> rsp_pte_o[PTE_P] && rsp_pte_o[PTE_A]);

  // R6: successful write leaves the final entry dirty
  a_r6_write_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_fault_o == 2'd0) && (acc_q == ACC_WR) |-> rsp_pte_o[PTE_D]);

  // R9: no memory traffic while idle, response is a single pulse
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !rsp_valid_o);

  a_r9_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [47:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        req_user;
  logic [39:0] root_ppn;
  logic        mem_req, mem_we, mem_ack;
  logic [51:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [39:0] rsp_ppn;
  logic [51:0] rsp_paddr;
  logic [63:0] rsp_pte;

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_acc_i(req_acc), .req_user_i(req_user), .root_ppn_i(root_ppn),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_ppn_o(rsp_ppn),
    .rsp_paddr_o(rsp_paddr), .rsp_pte_o(rsp_pte)
  );

  localparam logic [63:0] F_P = 64'h1, F_RW = 64'h2, F_US = 64'h4;
  localparam logic [63:0] F_XD = 64'h8000_0000_0000_0000;
  localparam logic [63:0] F_ALL = F_P | F_RW | F_US;
  localparam logic [39:0] ROOT = 40'h00100;

  logic [63:0] mem [logic [51:0]];
  int n_chk = 0, n_fail = 0;
  int dly = 1, cnt = 0, cyc = 0, ex_lat = 0;
  bit waiting = 0, done = 0;
  string tag;

  logic [51:0] ex_addr [$];
  logic        ex_we   [$];
  logic [63:0] ex_wd   [$];
  logic [1:0]  ex_flt;
  logic [39:0] ex_ppn;
  logic [51:0] ex_pa;
  logic [63:0] ex_pte;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic map(input logic [47:0] va, input logic [39:0] t1, t2, t3, leaf,
                     input logic [63:0] f0, f1, f2, f3);
    mem[{ROOT, va[47:39], 3'b0}] = f0 | {12'h0, t1, 12'h0};
    mem[{t1,   va[38:30], 3'b0}] = f1 | {12'h0, t2, 12'h0};
    mem[{t2,   va[29:21], 3'b0}] = f2 | {12'h0, t3, 12'h0};
    mem[{t3,   va[20:12], 3'b0}] = f3 | {12'h0, leaf, 12'h0};
  endtask

  task automatic predict(input logic [47:0] va, input logic [1:0] acc, input logic user);
    logic [39:0] b;
    logic [51:0] a;
    logic [63:0] e, ne;
    int r, w;
    b = ROOT; r = 0; w = 0;
    ex_addr.delete(); ex_we.delete(); ex_wd.delete();
    ex_flt = 2'd0; ex_ppn = '0; ex_pa = '0; ex_pte = '0;
    for (int l = 0; l < 4; l++) begin
      a = {b, va[47-9*l -: 9], 3'b000};
      e = rd(a);
      ex_addr.push_back(a); ex_we.push_back(1'b0); ex_wd.push_back(64'h0); r++;
      if (!e[0]) begin ex_flt = 2'd1; ex_pte = e; break; end
      if ((acc == 2'd1 && !e[1]) || (user && !e[2]) || (acc == 2'd2 && e[63])) begin
        ex_flt = 2'd2; ex_pte = e; break;
      end
      ne = e | 64'h20;
      if (l == 3 && acc == 2'd1) ne = ne | 64'h40;
      if (ne != e) begin
        ex_addr.push_back(a); ex_we.push_back(1'b1); ex_wd.push_back(ne); w++;
      end
      if (l == 3) begin
        ex_ppn = ne[51:12]; ex_pa = {ne[51:12], va[11:0]}; ex_pte = ne;
      end else begin
        b = e[51:12];
      end
    end
    ex_lat = r * (dly + 1) + w * dly + 1;
  endtask

  task automatic service();
    if (mem_ack) begin mem_ack = 1'b0; cnt = 0; end
    if (mem_req) begin
      cnt++;
      if (cnt == dly) begin
        mem_ack = 1'b1;
        mem_rdata = rd(mem_addr);
        if (ex_addr.size() == 0) begin
          check("R7 unexpected access", 64'(mem_addr), 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          check("R1 entry address", 64'(mem_addr), 64'(ex_addr[0]));
          check("R7 access order", 64'(mem_we), 64'(ex_we[0]));
          if (ex_we[0] && mem_we) check("R5 writeback value", mem_wdata, ex_wd[0]);
          void'(ex_addr.pop_front()); void'(ex_we.pop_front()); void'(ex_wd.pop_front());
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
      end
    end
  endtask

  task automatic monitor();
    if (waiting) begin
      check("R9 ready while busy", 64'(req_ready), 64'h0);
      check("R9 response cycle", 64'(rsp_valid), 64'(cyc == ex_lat));
      if (rsp_valid) begin
        check({tag, " fault code"}, 64'(rsp_fault), 64'(ex_flt));
        check("R8 page number", 64'(rsp_ppn), 64'(ex_ppn));
        check("R8 physical address", 64'(rsp_paddr), 64'(ex_pa));
        check("R8 entry", rsp_pte, ex_pte);
        check("R7 all accesses made", 64'(ex_addr.size()), 64'h0);
        waiting = 0;
      end else if (cyc > ex_lat) begin
        waiting = 0;
      end
    end else begin
      check("R9 idle ready", 64'(req_ready), 64'h1);
      check("R9 no stray response", 64'(rsp_valid), 64'h0);
    end
  endtask

  task automatic walk(input logic [47:0] va, input logic [1:0] acc, input logic user, input string t);
    predict(va, acc, user);
    tag = t;
    req_vaddr = va; req_acc = acc; req_user = user; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; waiting = 1; cyc = 1;
    service(); monitor();
    while (waiting) begin
      @(negedge clk); cyc++;
      service(); monitor();
    end
    @(negedge clk); service(); monitor();
  endtask

  localparam logic [47:0] VA1 = 48'h1234_5678_9ABC;
  localparam logic [47:0] VA2 = 48'h0000_4020_3FFF;
  localparam logic [47:0] VA3 = 48'h0080_1111_2222;
  localparam logic [47:0] VA4 = 48'h0100_0000_0000;
  localparam logic [47:0] VA5 = 48'h0180_0000_1000;
  localparam logic [47:0] VA6 = 48'h7FC0_0000_0000;
  localparam logic [47:0] VA7 = 48'hFFFF_FFFF_F123;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_user = 1'b0;
    root_ppn = ROOT; mem_ack = 1'b0; mem_rdata = '0;
    map(VA1, 40'h201, 40'h202, 40'h203, 40'h0ABCD, F_ALL, F_ALL, F_ALL, F_ALL);
    map(VA2, 40'h301, 40'h302, 40'h303, 40'h77777, F_ALL, F_ALL, F_ALL, F_ALL | F_XD);
    map(VA3, 40'h401, 40'h402, 40'h403, 40'h12345, F_ALL, F_P | F_RW, F_ALL, F_ALL);
    map(VA4, 40'h501, 40'h502, 40'h503, 40'h54321, F_ALL, F_ALL, F_ALL, F_P | F_US);
    map(VA5, 40'h601, 40'h602, 40'h603, 40'h0F0F0, F_ALL, F_ALL, 64'h0, F_ALL);
    map(VA7, 40'h701, 40'h702, 40'h703, 40'hFFFFF, F_ALL, F_ALL, F_ALL, F_ALL);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset ready", 64'(req_ready), 64'h1);
    check("R9 reset no request", 64'(mem_req), 64'h0);
    check("R9 reset no response", 64'(rsp_valid), 64'h0);

    walk(VA1, 2'd0, 1'b0, "R2");   // first touch: accessed set at every level
    walk(VA1, 2'd0, 1'b0, "R5");   // flags already set: no writeback
    walk(VA1, 2'd1, 1'b0, "R6");   // write: dirty only in final entry
    walk(VA1, 2'd1, 1'b1, "R6");   // nothing left to update
    walk(VA2, 2'd2, 1'b0, "R4");   // fetch from execute-disabled page
    walk(VA2, 2'd0, 1'b1, "R8");   // read of same page succeeds
    walk(VA3, 2'd0, 1'b1, "R4");   // user meets supervisor table
    walk(VA3, 2'd0, 1'b0, "R4");   // supervisor passes
    walk(VA4, 2'd1, 1'b0, "R4");   // write to read-only page
    walk(VA4, 2'd3, 1'b0, "R10");  // code 3 acts as a read
    walk(VA5, 2'd0, 1'b0, "R3");   // absent at level 2
    walk(VA6, 2'd1, 1'b0, "R3");   // absent at level 0
    dly = 3;
    walk(VA7, 2'd1, 1'b0, "R9");   // longer acknowledge delay, full update
    dly = 2;
    walk(VA7, 2'd2, 1'b0, "R1");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule